// File: doc/BRIEF.md
# In-Place Radix-2 FFT Engine

This block computes a complex fixed-point fast Fourier transform of a power-of-two length N, set at elaboration, over samples held in an external single-read, single-write RAM. After a start pulse it runs every butterfly stage in place over that RAM. It issues one read address per clock and, five clocks later, one write per clock. At the end it raises a one-cycle done pulse. A sticky flag reports whether any butterfly sum left the signed data range.

Each RAM word carries one complex sample, with the real part in the upper W bits and the imaginary part in the lower W bits, both two's complement. The engine addresses the RAM through a bit-reversal of the logical sample index. The caller therefore loads the input in natural order and reads the spectrum back in bit-reversed order. The twiddle table is computed at elaboration and held inside the block. Two real multipliers are shared over two clocks to form each complex product. No scaling is applied between stages.

Top module: `fft_engine`

## Requirements
- R1: While reset is high and in the first cycle after it, busy, done, ovf and wr_en are 0 and rd_addr is 0.
- R2: A start seen high on a rising edge while busy is 0 is accepted: busy becomes 1 and ovf clears. A start seen while busy is 1 is ignored; it changes neither the timing nor the result of the running transform.
- R3: done is high for exactly one cycle. It rises on the (N·log2(N)+7)-th rising edge after the edge that accepted start, so a transform spans N·log2(N)+8 edges including that one. busy falls on the same edge that raises done.
- R4: Stages run with group size G = 2, 4, …, N, with N/G sections per stage and G/2 butterflies per section, in ascending order. Each butterfly reads its top element in one cycle and its bottom element in the next. For butterfly i of section s, the top element is at logical index s·G+i and the bottom element is at s·G+i+G/2. The physical RAM address is the log2(N)-bit reversal of the logical index; for N = 16 the first four reads are at addresses 0, 8, 4, 12. When idle, rd_addr is 0.
- R5: Every read slot produces exactly one write, five cycles after the read, to the address that slot read. A transform makes N·log2(N) writes, and wr_en is only high while busy.
- R6: The twiddle for index k is round(cos(2πk/N)·(2^(W-1)−1)) for the real part and round(−sin(2πk/N)·(2^(W-1)−1)) for the imaginary part, with halves rounded away from zero. A butterfly uses index i·(N/G). The product T = W·B has each component equal to the exact sum of two products, arithmetically shifted right by W−1 (floor). The top element becomes A+T and the bottom element becomes A−T. Each component wraps to W bits.
- R7: ovf is set when any real or imaginary component of A+T or A−T falls outside [−2^(W-1), 2^(W-1)−1]. It stays set until the next accepted start, including while idle.
- R8: After done, the address given by the bit reversal of k holds spectrum bin k of the fixed-point algorithm of R6 applied to the loaded samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a transform when idle |
| busy | output | 1 | Transform in progress |
| done | output | 1 | One-cycle completion pulse |
| ovf | output | 1 | Sticky butterfly range overflow |
| rd_addr | output | log2(N) | RAM read address |
| rd_data | input | 2·W | RAM read data, one cycle after rd_addr, real part upper |
| wr_en | output | 1 | RAM write enable |
| wr_addr | output | log2(N) | RAM write address |
| wr_data | output | 2·W | RAM write data, real part upper |

## Verification
The bench targets these corner cases:

- **Read-after-write between stages.** The write-back of one stage lags its reads by five cycles, so the first reads of the next stage could catch stale words. A design with a deeper pipeline, or with the stage ordering wrong, would return bins that miss the reference spectrum on random data.
- **Full-scale input.** This must both set the sticky flag and wrap exactly as the reference does. Saturating instead of wrapping, or missing a component in the range check, shows up as a flag or spectrum mismatch.
- **Twiddle index and floor shift.** An impulse placed off sample zero exercises every twiddle entry. A mis-scaled twiddle index or a rounded shift instead of a floored one changes the low bits of those bins.
- **Start while busy and flag clearing.** A start pulse in the middle of a run must leave the done cycle unchanged. A later clean run must show the flag cleared.

// File: rtl/fft_pkg.sv
package fft_pkg;

    typedef enum logic {
        PH_TOP = 1'b0,
        PH_BOT = 1'b1
    } phase_e;

    // Reverse the low nb bits of v.
    function automatic logic [31:0] bit_reverse(input logic [31:0] v, input int nb);
        logic [31:0] r;
        r = '0;
        for (int j = 0; j < nb; j++) begin
            r[nb-1-j] = v[j];
        end
        return r;
    endfunction

    // Twiddle coefficient for index k of an n-point transform, w-bit signed,
    // scaled by 2^(w-1)-1 and rounded half away from zero.
    function automatic int twiddle_coef(input int k, input int n, input int w, input bit imag_part);
        real ang;
        real scale;
        real v;
        ang   = 6.283185307179586 * real'(k) / real'(n);
        scale = real'((1 << (w - 1)) - 1);
        v     = imag_part ? -$sin(ang) * scale : $cos(ang) * scale;
        return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(0.5 - v);
    endfunction

endpackage

// File: rtl/fft_addr_gen.sv
module fft_addr_gen #(
    parameter int LOG = 4,
    parameter int SW  = 2
) (
    input  logic [LOG+SW-1:0] slot,
    output fft_pkg::phase_e   phase,
    output logic [LOG-1:0]    top_phys,
    output logic [LOG-1:0]    bot_phys,
    output logic [LOG-2:0]    tw_idx
);
    logic [SW-1:0]  stage;
    logic [LOG-1:0] bfly;
    logic [LOG-1:0] low_mask;
    logic [LOG-1:0] top_log;
    logic [LOG-1:0] bot_log;

    assign phase = fft_pkg::phase_e'(slot[0]);
    assign stage = slot[LOG+SW-1:LOG];
    assign bfly  = {1'b0, slot[LOG-1:1]};

    always_comb begin
        low_mask = (LOG'(1) << stage) - LOG'(1);
        // Insert a zero bit at position 'stage' into the butterfly number.
        top_log  = ((bfly & ~low_mask) << 1) | (bfly & low_mask);
        bot_log  = top_log | (LOG'(1) << stage);
        tw_idx   = (LOG-1)'((bfly & low_mask) << (LOG - 1 - int'(stage)));
        top_phys = LOG'(fft_pkg::bit_reverse(32'(top_log), LOG));
        bot_phys = LOG'(fft_pkg::bit_reverse(32'(bot_log), LOG));
    end
endmodule

// File: rtl/fft_twiddle_rom.sv
module fft_twiddle_rom #(
    parameter int N = 16,
    parameter int W = 16,
    parameter int LOG = $clog2(N)
) (
    input  logic [LOG-2:0]      idx,
    output logic signed [W-1:0] tw_re,
    output logic signed [W-1:0] tw_im
);
    localparam int HALF = N / 2;

    logic signed [W-1:0] rom_re [HALF];
    logic signed [W-1:0] rom_im [HALF];

    for (genvar k = 0; k < HALF; k++) begin : g_entry
        localparam int CRE = fft_pkg::twiddle_coef(k, N, W, 1'b0);
        localparam int CIM = fft_pkg::twiddle_coef(k, N, W, 1'b1);
        assign rom_re[k] = W'(CRE);
        assign rom_im[k] = W'(CIM);
    end

    assign tw_re = rom_re[idx];
    assign tw_im = rom_im[idx];
endmodule

// File: rtl/fft_butterfly.sv
module fft_butterfly #(
    parameter int W  = 16,
    parameter int AW = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  fft_pkg::phase_e     in_phase,
    input  logic [AW-1:0]       in_top_addr,
    input  logic [AW-1:0]       in_bot_addr,
    input  logic signed [W-1:0] tw_re,
    input  logic signed [W-1:0] tw_im,
    input  logic [2*W-1:0]      rd_data,
    output logic                wr_en,
    output logic [AW-1:0]       wr_addr,
    output logic [2*W-1:0]      wr_data,
    output logic                ovf_evt
);
    typedef struct packed {
        logic signed [W-1:0] re;
        logic signed [W-1:0] im;
    } cplx_t;

    typedef struct packed {
        logic [AW-1:0] top;
        logic [AW-1:0] bot;
    } pair_t;

    localparam int PW = 2 * W;   // product width
    localparam int TW = W + 2;   // shifted product-sum width
    localparam int SW = W + 3;   // butterfly sum width

    function automatic logic out_of_range(input logic signed [SW-1:0] v);
        return v[SW-1:W-1] != {4{v[W-1]}};
    endfunction

    cplx_t rd;
    assign rd = cplx_t'(rd_data);

    // stage A: top element and twiddle
    cplx_t               a_q;
    pair_t               pair_a;
    logic signed [W-1:0] twr_q, twi_q;
    // stage 3: bottom element captured, first product pair in flight
    logic                v3;
    cplx_t               a3, b_q;
    pair_t               pair3;
    // shared multipliers
    logic signed [PW-1:0] mx, my, px_q, py_q;
    // stage 4: real part of product known
    logic                 v4;
    cplx_t                a4;
    pair_t                pair4;
    logic signed [TW-1:0] t_re_q;
    // stage 5: bottom result waiting for its write slot
    logic                 v5;
    logic [AW-1:0]        addr5;
    cplx_t                diff_q;

    // Two multipliers: real cross terms in the bottom-read cycle, imaginary next.
    always_comb begin
        if (v3) begin
            mx = twr_q * b_q.im;
            my = twi_q * b_q.re;
        end else begin
            mx = twr_q * rd.re;
            my = twi_q * rd.im;
        end
    end

    logic signed [PW:0]   diff_p, sum_p;
    logic signed [TW-1:0] t_im;
    logic signed [SW-1:0] s_re, s_im, d_re, d_im;

    always_comb begin
        diff_p = (PW+1)'(px_q) - (PW+1)'(py_q);
        sum_p  = (PW+1)'(px_q) + (PW+1)'(py_q);
        t_im   = TW'(sum_p >>> (W - 1));
        s_re   = SW'(a4.re) + SW'(t_re_q);
        s_im   = SW'(a4.im) + SW'(t_im);
        d_re   = SW'(a4.re) - SW'(t_re_q);
        d_im   = SW'(a4.im) - SW'(t_im);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q     <= '0;
            pair_a  <= '0;
            twr_q   <= '0;
            twi_q   <= '0;
            v3      <= 1'b0;
            a3      <= '0;
            b_q     <= '0;
            pair3   <= '0;
            px_q    <= '0;
            py_q    <= '0;
            v4      <= 1'b0;
            a4      <= '0;
            pair4   <= '0;
            t_re_q  <= '0;
            v5      <= 1'b0;
            addr5   <= '0;
            diff_q  <= '0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            ovf_evt <= 1'b0;
        end else begin
            if (in_valid && in_phase == fft_pkg::PH_TOP) begin
                a_q    <= rd;
                twr_q  <= tw_re;
                twi_q  <= tw_im;
                pair_a <= '{top: in_top_addr, bot: in_bot_addr};
            end
            v3 <= in_valid && in_phase == fft_pkg::PH_BOT;
            if (in_valid && in_phase == fft_pkg::PH_BOT) begin
                a3    <= a_q;
                b_q   <= rd;
                pair3 <= pair_a;
            end
            px_q <= mx;
            py_q <= my;
            v4   <= v3;
            if (v3) begin
                t_re_q <= TW'(diff_p >>> (W - 1));
                a4     <= a3;
                pair4  <= pair3;
            end
            v5      <= v4;
            ovf_evt <= v4 && (out_of_range(s_re) || out_of_range(s_im) ||
                              out_of_range(d_re) || out_of_range(d_im));
            if (v4) begin
                diff_q  <= '{re: W'(d_re), im: W'(d_im)};
                addr5   <= pair4.bot;
                wr_en   <= 1'b1;
                wr_addr <= pair4.top;
                wr_data <= {W'(s_re), W'(s_im)};
            end else if (v5) begin
                wr_en   <= 1'b1;
                wr_addr <= addr5;
                wr_data <= diff_q;
            end else begin
                wr_en   <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/fft_engine.sv
module fft_engine #(
    parameter int N = 16,
    parameter int W = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    output logic                   busy,
    output logic                   done,
    output logic                   ovf,
    output logic [$clog2(N)-1:0]   rd_addr,
    input  logic [2*W-1:0]         rd_data,
    output logic                   wr_en,
    output logic [$clog2(N)-1:0]   wr_addr,
    output logic [2*W-1:0]         wr_data
);
    localparam int LOG   = $clog2(N);
    localparam int SW    = (LOG > 1) ? $clog2(LOG) : 1;
    localparam int SLOTS = N * LOG;
    localparam int LAST  = SLOTS + 6;
    localparam int CW    = $clog2(SLOTS + 8) + 1;

    logic [CW-1:0]   cnt;
    logic            issue_v;
    fft_pkg::phase_e phase;
    logic [LOG-1:0]  top_phys, bot_phys;
    logic [LOG-2:0]  tw_idx;

    logic            d1_v;
    fft_pkg::phase_e d1_phase;
    logic [LOG-1:0]  d1_top, d1_bot;
    logic [LOG-2:0]  d1_tw;

    logic signed [W-1:0] tw_re, tw_im;
    logic                ovf_evt;

    assign issue_v = busy && (cnt < CW'(SLOTS));

    fft_addr_gen #(.LOG(LOG), .SW(SW)) u_addr (
        .slot     (cnt[LOG+SW-1:0]),
        .phase    (phase),
        .top_phys (top_phys),
        .bot_phys (bot_phys),
        .tw_idx   (tw_idx)
    );

    assign rd_addr = !issue_v ? '0 :
                     (phase == fft_pkg::PH_BOT) ? bot_phys : top_phys;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            done <= 1'b0;
            ovf  <= 1'b0;
            cnt  <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy <= 1'b1;
                    ovf  <= 1'b0;
                    cnt  <= '0;
                end
            end else begin
                cnt <= cnt + CW'(1);
                if (ovf_evt) ovf <= 1'b1;
                if (cnt == CW'(LAST)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            d1_v     <= 1'b0;
            d1_phase <= fft_pkg::PH_TOP;
            d1_top   <= '0;
            d1_bot   <= '0;
            d1_tw    <= '0;
        end else begin
            d1_v     <= issue_v;
            d1_phase <= phase;
            d1_top   <= top_phys;
            d1_bot   <= bot_phys;
            d1_tw    <= tw_idx;
        end
    end

    fft_twiddle_rom #(.N(N), .W(W), .LOG(LOG)) u_rom (
        .idx   (d1_tw),
        .tw_re (tw_re),
        .tw_im (tw_im)
    );

    fft_butterfly #(.W(W), .AW(LOG)) u_bfly (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (d1_v),
        .in_phase    (d1_phase),
        .in_top_addr (d1_top),
        .in_bot_addr (d1_bot),
        .tw_re       (tw_re),
        .tw_im       (tw_im),
        .rd_data     (rd_data),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .ovf_evt     (ovf_evt)
    );
endmodule

// File: rtl/fft_engine_chk.sv
module fft_engine_chk #(
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          ovf,
    input logic [AW-1:0] rd_addr,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr
);
    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && !done && !ovf));

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R3
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R4
    idle_addr_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (rd_addr == '0));

    // R5
    write_busy_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> busy);

    // R5
    write_addr_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_addr == $past(rd_addr, 5)));

    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf && busy) |=> ovf);

    // R7
    ovf_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(ovf));
endmodule

bind fft_engine fft_engine_chk #(.AW(LOG)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .ovf     (ovf),
    .rd_addr (rd_addr),
    .wr_en   (wr_en),
    .wr_addr (wr_addr)
);

// File: tb/tb_fft_engine.sv
`timescale 1ns/1ps
module tb_fft_engine;
    localparam int N     = 16;
    localparam int W     = 16;
    localparam int LOG   = $clog2(N);
    localparam int SLOTS = N * LOG;
    localparam int DONE_K = SLOTS + 7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic busy, done, ovf, wr_en;
    logic [LOG-1:0] rd_addr, wr_addr;
    logic [2*W-1:0] rd_data, wr_data;

    always #2.5 clk = ~clk;

    fft_engine #(.N(N), .W(W)) dut (
        .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .ovf(ovf),
        .rd_addr(rd_addr), .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data)
    );

    // bench RAM: registered read, write on the same edge (read sees old word)
    logic [2*W-1:0] mem [N];
    logic [2*W-1:0] init_vec [N];
    logic load_req = 1'b0;
    always_ff @(posedge clk) begin
        if (load_req) begin
            for (int i = 0; i < N; i++) mem[i] <= init_vec[i];
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
        rd_data <= mem[rd_addr];
    end

    int n_chk = 0;
    int n_bad = 0;
    longint in_re [N];
    longint in_im [N];
    logic [2*W-1:0] exp_mem [N];
    bit ref_ovf;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    function automatic int brev(input int v);
        int r = 0;
        for (int j = 0; j < LOG; j++) if (v[j]) r |= 1 << (LOG - 1 - j);
        return r;
    endfunction

    function automatic longint tw_val(input int k, input bit im);
        real a = 2.0 * 3.141592653589793 * real'(k) / real'(N);
        real s = real'((1 << (W - 1)) - 1);
        real v = im ? -$sin(a) * s : $cos(a) * s;
        if (v >= 0.0) return longint'($rtoi(v + 0.5));
        return -longint'($rtoi(0.5 - v));
    endfunction

    function automatic longint wrapw(input longint v);
        logic signed [W-1:0] t = v[W-1:0];
        return longint'(t);
    endfunction

    function automatic bit oor(input longint v);
        return (v < -(longint'(1) << (W - 1))) || (v > (longint'(1) << (W - 1)) - 1);
    endfunction

    // reference model of the fixed-point algorithm (R6, R8)
    task automatic build_ref();
        longint xr [N];
        longint xi [N];
        ref_ovf = 1'b0;
        for (int j = 0; j < N; j++) begin
            xr[j] = in_re[brev(j)];
            xi[j] = in_im[brev(j)];
            init_vec[j] = {in_re[j][W-1:0], in_im[j][W-1:0]};
        end
        for (int p = 0; p < LOG; p++) begin
            int g = 2 << p;
            int h = 1 << p;
            int secs = N / g;
            for (int s = 0; s < secs; s++) begin
                for (int i = 0; i < h; i++) begin
                    longint wr = tw_val(i * secs, 1'b0);
                    longint wi = tw_val(i * secs, 1'b1);
                    int ta = s * g + i;
                    int ba = ta + h;
                    longint tre = (wr * xr[ba] - wi * xi[ba]) >>> (W - 1);
                    longint tim = (wr * xi[ba] + wi * xr[ba]) >>> (W - 1);
                    longint s0 = xr[ta] + tre;
                    longint s1 = xi[ta] + tim;
                    longint s2 = xr[ta] - tre;
                    longint s3 = xi[ta] - tim;
                    if (oor(s0) || oor(s1) || oor(s2) || oor(s3)) ref_ovf = 1'b1;
                    xr[ta] = wrapw(s0); xi[ta] = wrapw(s1);
                    xr[ba] = wrapw(s2); xi[ba] = wrapw(s3);
                end
            end
        end
        for (int k = 0; k < N; k++) exp_mem[brev(k)] = {xr[k][W-1:0], xi[k][W-1:0]};
    endtask

    task automatic run_fft(input bit poke, input bit chk_order, input string tag);
        int done_at = -1;
        int done_cnt = 0;
        int wcount = 0;
        int busy_bad = 0;
        logic [LOG-1:0] first_rd [4];
        build_ref();
        @(negedge clk); load_req = 1'b1;
        @(negedge clk); load_req = 1'b0; start = 1'b1;
        @(posedge clk);
        for (int k = 0; k < SLOTS + 12; k++) begin
            @(negedge clk);
            if (k == 0) start = 1'b0;
            if (poke && k == 20) start = 1'b1;
            if (poke && k == 21) start = 1'b0;
            if (done) begin
                done_cnt++;
                if (done_at < 0) done_at = k;
            end
            if (k < DONE_K && !busy) busy_bad++;
            if (wr_en) wcount++;
            if (k < 4) first_rd[k] = rd_addr;
        end
        check(done_at == DONE_K, "R3", {tag, " done cycle"}, done_at, DONE_K);
        check(done_cnt == 1, "R3", {tag, " done width"}, done_cnt, 1);
        check(busy_bad == 0 && !busy, "R2", {tag, " busy span"}, busy_bad, 0);
        check(wcount == SLOTS, "R5", {tag, " write count"}, wcount, SLOTS);
        check(ovf == ref_ovf, "R7", {tag, " overflow flag"}, ovf, ref_ovf);
        if (chk_order) begin
            check(first_rd[0] == 0,     "R4", "read 0", first_rd[0], 0);
            check(first_rd[1] == N/2,   "R4", "read 1", first_rd[1], N/2);
            check(first_rd[2] == N/4,   "R4", "read 2", first_rd[2], N/4);
            check(first_rd[3] == 3*N/4, "R4", "read 3", first_rd[3], 3*N/4);
        end
        for (int a = 0; a < N; a++)
            check(mem[a] == exp_mem[a], "R8", {tag, " bin word"}, mem[a], exp_mem[a]);
    endtask

    task automatic fill_rand(input int amp);
        for (int i = 0; i < N; i++) begin
            in_re[i] = longint'($urandom_range(0, 2 * amp)) - amp;
            in_im[i] = longint'($urandom_range(0, 2 * amp)) - amp;
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    int cycles = 0;
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd7301));
        for (int i = 0; i < N; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy && !done, "R1", "busy/done in reset", {busy, done}, 0);
        check(!wr_en && !ovf, "R1", "wr_en/ovf in reset", {wr_en, ovf}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(rd_addr == 0 && !busy && !done && !wr_en && !ovf, "R1", "after reset",
              {rd_addr, busy, done, wr_en, ovf}, 0);

        // all zero input: zero spectrum, no overflow (R6)
        for (int i = 0; i < N; i++) begin in_re[i] = 0; in_im[i] = 0; end
        run_fft(1'b0, 1'b1, "zeros");

        // impulse at sample 0 (R6)
        for (int i = 0; i < N; i++) begin in_re[i] = 0; in_im[i] = 0; end
        in_re[0] = 1000;
        run_fft(1'b0, 1'b0, "impulse0");

        // complex impulse off zero touches every twiddle (R6)
        for (int i = 0; i < N; i++) begin in_re[i] = 0; in_im[i] = 0; end
        in_re[5] = 1500; in_im[5] = -700;
        run_fft(1'b0, 1'b0, "impulse5");

        // random, in range (R6, R8)
        fill_rand(1000);
        run_fft(1'b0, 1'b0, "rand_a");

        // start pulse while busy is ignored (R2)
        fill_rand(1000);
        run_fft(1'b1, 1'b0, "rand_poke");

        // full-scale real input overflows and wraps (R7)
        for (int i = 0; i < N; i++) begin in_re[i] = (1 << (W - 1)) - 1; in_im[i] = 0; end
        run_fft(1'b0, 1'b0, "fullscale");
        check(ovf == 1'b1, "R7", "sticky while idle", ovf, 1);

        // most negative value on both parts (R7)
        for (int i = 0; i < N; i++) begin in_re[i] = -(1 << (W - 1)); in_im[i] = -(1 << (W - 1)); end
        run_fft(1'b0, 1'b0, "negscale");

        // random full range
        fill_rand((1 << (W - 1)) - 1);
        run_fft(1'b0, 1'b0, "rand_full");

        // flag clears on the next accepted start (R7)
        fill_rand(500);
        run_fft(1'b0, 1'b0, "rand_clear");
        check(ovf == 1'b0, "R7", "cleared by start", ovf, 0);

        finish_run();
    end
endmodule